// File: doc/BRIEF.md
# Panel Power Sequencer

This block brings a display panel up and down in a fixed order across three supply and signal domains. When its request input goes high it turns on panel supply first. It then turns on the video data drive, and finally the backlight. When the request drops it reverses that order. The backlight always goes dark first, then the data drive, then panel supply. Four separately programmed 16-bit delays set the gaps between these steps. Each delay counts in ticks of a millisecond-scale time base.

The time base is either a single-cycle pulse supplied from outside, or an internal prescaler that divides the core clock. If the request falls part-way through power-up, the sequence turns around at the step it has reached and leaves by the normal shut-down path. A request that rises during shut-down waits until the panel is fully off. A busy flag shows that a gap is being timed. A ready flag shows a settled state: fully off or fully on.

Top module: `pps_seq`

## Requirements
- R1: While reset is asserted, and right after it, supply, data and backlight enables are low, ready is high and busy is low.
- R2: The only enable combinations ever driven ({supply,data,backlight}) are 000, 100, 110 and 111, so data is never on without supply and backlight never without data.
- R3: On power-up the supply-to-data gap lasts exactly `rise_gap_sd` consumed ticks; a value of 0 makes the gap one clock cycle.
- R4: On power-up the data-to-backlight gap lasts exactly `rise_gap_db` consumed ticks; 0 gives one cycle.
- R5: On power-down the backlight enable drops on the first clock edge after the request falls, while data and supply stay on.
- R6: On power-down data stays on for `fall_gap_bd` ticks after the backlight drops, then supply stays on for `fall_gap_ds` ticks after data drops; 0 gives one cycle.
- R7: If the request falls while only supply is on, data never enables, and supply drops after `fall_gap_ds` ticks.
- R8: If the request falls while supply and data are on and backlight is not, backlight never enables, data drops after `fall_gap_bd` ticks, and supply drops `fall_gap_ds` ticks after that.
- R9: A request raised during power-down does not stop the power-down; all enables are low for exactly one cycle before power-up starts again.
- R10: Busy is high exactly when the enables show 100 or 110 during a timed gap, and ready equals the inverse of busy.
- R11: With `use_ext_tick` = 1 the delays count pulses on `ext_tick`. With it at 0, an internal tick fires once every `presc_div`+1 clock cycles and `ext_tick` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_req | input | 1 | High requests panel on, low requests panel off |
| use_ext_tick | input | 1 | 1 selects ext_tick as time base, 0 the internal prescaler |
| ext_tick | input | 1 | External single-cycle time-base pulse |
| presc_div | input | 16 | Internal prescaler divide value minus one |
| rise_gap_sd | input | 16 | Ticks from supply on to data on |
| rise_gap_db | input | 16 | Ticks from data on to backlight on |
| fall_gap_bd | input | 16 | Ticks from backlight off to data off |
| fall_gap_ds | input | 16 | Ticks from data off to supply off |
| vcc_en | output | 1 | Panel supply enable |
| data_en | output | 1 | Video data drive enable |
| bl_en | output | 1 | Backlight enable |
| busy | output | 1 | A gap is being timed |
| ready | output | 1 | Fully off or fully on |

## Verification
The assertions assume that the gap and divider inputs do not change while a gap is being timed. They also assume the external tick is a one-cycle pulse. The bench changes configuration only when the block is idle. It drives the external tick as one pulse every three cycles, so the number of ticks seen inside each enable window must equal the programmed value exactly. All 256 combinations of gap values 0 to 3 are swept. With the internal prescaler the tick phase is unknown, so those windows are checked against a computed cycle range, or against an exact length when the divide value is zero.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_UP_VCC  = 3'd1,
    ST_UP_DATA = 3'd2,
    ST_ON      = 3'd3,
    ST_DN_DATA = 3'd4,
    ST_DN_VCC  = 3'd5
  } pps_state_e;

  typedef enum logic [1:0] {
    GAP_RISE_SD = 2'd0,
    GAP_RISE_DB = 2'd1,
    GAP_FALL_BD = 2'd2,
    GAP_FALL_DS = 2'd3
  } pps_gap_e;

endpackage

// File: rtl/pps_rst_sync.sv
module pps_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pps_tick_gen.sv
module pps_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_ext_i,
  input  logic             ext_tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] pcnt_q;
  logic [DIV_W-1:0] pcnt_d;
  logic             wrap;
  logic             pcnt_en;

  always_comb begin
    wrap    = (pcnt_q >= div_i);
    pcnt_d  = wrap ? '0 : pcnt_q + 1'b1;
    pcnt_en = !use_ext_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (pcnt_en) pcnt_q <= pcnt_d;
  end

  assign tick_o = use_ext_i ? ext_tick_i : wrap;

  // R11: internal ticks are spaced div+1 cycles apart
  a_r11_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_ext_i && wrap && div_i != '0 && $stable(use_ext_i)) |=>
      (!wrap || div_i != $past(div_i) || use_ext_i));

endmodule

// File: rtl/pps_gap_cnt.sv
module pps_gap_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         tick_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i || (tick_i && cnt_q != '0);
    cnt_d  = load_i ? val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);

  // R3: one step down per consumed tick
  a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && tick_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R6: an expired gap stays expired until reloaded
  a_r6_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0));

endmodule

// File: rtl/pps_fsm.sv
module pps_fsm
  import pps_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_i,
  input  logic     done_i,
  output logic     load_o,
  output pps_gap_e gap_o,
  output logic     vcc_o,
  output logic     data_o,
  output logic     bl_o,
  output logic     busy_o,
  output logic     ready_o
);

  pps_state_e state_q, state_d;
  logic vcc_d, data_d, bl_d, busy_d, ready_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    gap_o   = GAP_RISE_SD;
    unique case (state_q)
      ST_OFF: begin
        if (req_i) begin
          state_d = ST_UP_VCC;
          load_o  = 1'b1;
          gap_o   = GAP_RISE_SD;
        end
      end
      ST_UP_VCC: begin
        if (!req_i) begin
          state_d = ST_DN_VCC;
          load_o  = 1'b1;
          gap_o   = GAP_FALL_DS;
        end else if (done_i) begin
          state_d = ST_UP_DATA;
          load_o  = 1'b1;
          gap_o   = GAP_RISE_DB;
        end
      end
      ST_UP_DATA: begin
        if (!req_i) begin
          state_d = ST_DN_DATA;
          load_o  = 1'b1;
          gap_o   = GAP_FALL_BD;
        end else if (done_i) begin
          state_d = ST_ON;
        end
      end
      ST_ON: begin
        if (!req_i) begin
          state_d = ST_DN_DATA;
          load_o  = 1'b1;
          gap_o   = GAP_FALL_BD;
        end
      end
      ST_DN_DATA: begin
        if (done_i) begin
          state_d = ST_DN_VCC;
          load_o  = 1'b1;
          gap_o   = GAP_FALL_DS;
        end
      end
      ST_DN_VCC: begin
        if (done_i) state_d = ST_OFF;
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_comb begin
    vcc_d   = (state_d != ST_OFF);
    data_d  = (state_d == ST_UP_DATA) || (state_d == ST_ON) ||
              (state_d == ST_DN_DATA);
    bl_d    = (state_d == ST_ON);
    ready_d = (state_d == ST_OFF) || (state_d == ST_ON);
    busy_d  = !ready_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      vcc_o   <= 1'b0;
      data_o  <= 1'b0;
      bl_o    <= 1'b0;
      busy_o  <= 1'b0;
      ready_o <= 1'b1;
    end else begin
      state_q <= state_d;
      vcc_o   <= vcc_d;
      data_o  <= data_d;
      bl_o    <= bl_d;
      busy_o  <= busy_d;
      ready_o <= ready_d;
    end
  end

  // R9: once shutting down, only shutdown states or off follow
  a_r9_no_restart_mid_down: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DN_DATA || state_q == ST_DN_VCC) |=>
      (state_q == ST_DN_DATA || state_q == ST_DN_VCC || state_q == ST_OFF));

  // R5: a dropped request leaves the fully-on state at the next edge
  a_r5_leave_on: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ON && !req_i) |=> (state_q == ST_DN_DATA));

endmodule

// File: rtl/pps_seq.sv
module pps_seq
  import pps_pkg::*;
#(
  parameter int DLY_W = 16,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_req,
  input  logic             use_ext_tick,
  input  logic             ext_tick,
  input  logic [DIV_W-1:0] presc_div,
  input  logic [DLY_W-1:0] rise_gap_sd,
  input  logic [DLY_W-1:0] rise_gap_db,
  input  logic [DLY_W-1:0] fall_gap_bd,
  input  logic [DLY_W-1:0] fall_gap_ds,
  output logic             vcc_en,
  output logic             data_en,
  output logic             bl_en,
  output logic             busy,
  output logic             ready
);

  logic             rst_sync_n;
  logic             tick;
  logic             gap_load;
  logic             gap_done;
  pps_gap_e         gap_sel;
  logic [DLY_W-1:0] gap_val;

  pps_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pps_tick_gen #(.DIV_W(DIV_W)) u_tick_gen (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .use_ext_i  (use_ext_tick),
    .ext_tick_i (ext_tick),
    .div_i      (presc_div),
    .tick_o     (tick)
  );

  always_comb begin
    unique case (gap_sel)
      GAP_RISE_SD: gap_val = rise_gap_sd;
      GAP_RISE_DB: gap_val = rise_gap_db;
      GAP_FALL_BD: gap_val = fall_gap_bd;
      GAP_FALL_DS: gap_val = fall_gap_ds;
      default:     gap_val = rise_gap_sd;
    endcase
  end

  pps_gap_cnt #(.W(DLY_W)) u_gap_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (gap_load),
    .val_i  (gap_val),
    .tick_i (tick),
    .done_o (gap_done)
  );

  pps_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .req_i   (pwr_req),
    .done_i  (gap_done),
    .load_o  (gap_load),
    .gap_o   (gap_sel),
    .vcc_o   (vcc_en),
    .data_o  (data_en),
    .bl_o    (bl_en),
    .busy_o  (busy),
    .ready_o (ready)
  );

  // R2: enables nest
  a_r2_data_needs_vcc: assert property (@(posedge clk) disable iff (!rst_sync_n)
    data_en |-> vcc_en);
  a_r2_bl_needs_data: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bl_en |-> data_en);

  // R3: data turns on only after the first rise gap expired
  a_r3_data_after_gap: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(data_en) |-> $past(gap_done));

  // R4: backlight turns on only after the second rise gap expired
  a_r4_bl_after_gap: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(bl_en) |-> $past(gap_done));

  // R6: data and supply turn off only after their gaps expired
  a_r6_data_off_after_gap: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(data_en) |-> $past(gap_done));
  a_r6_vcc_off_after_gap: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(vcc_en) |-> $past(gap_done));

  // R10: settled states show all enables equal
  a_r10_ready_settled: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ready |-> (vcc_en == bl_en && !busy));

endmodule

// File: tb/pps_seq_bench.sv
module pps_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 2000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pwr_req;
  logic        use_ext_tick;
  logic        ext_tick = 1'b0;
  logic [15:0] presc_div;
  logic [15:0] rise_gap_sd, rise_gap_db, fall_gap_bd, fall_gap_ds;
  logic        vcc_en, data_en, bl_en, busy, ready;

  int checks = 0;
  int errors = 0;
  int tph    = 0;
  logic tick_force = 1'b0;
  logic done_flag  = 1'b0;

  pps_seq u_pps_seq (
    .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .use_ext_tick(use_ext_tick),
    .ext_tick(ext_tick), .presc_div(presc_div),
    .rise_gap_sd(rise_gap_sd), .rise_gap_db(rise_gap_db),
    .fall_gap_bd(fall_gap_bd), .fall_gap_ds(fall_gap_ds),
    .vcc_en(vcc_en), .data_en(data_en), .bl_en(bl_en),
    .busy(busy), .ready(ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // external tick: one pulse every three cycles
  always @(posedge clk) begin
    tph      <= (tph == 2) ? 0 : tph + 1;
    ext_tick <= tick_force | (tph == 2);
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_gap(input string tag, input int n, input int c, input int t);
    if (n == 0) chk(tag, c, 1);
    else        chk(tag, t, n);
  endtask

  function automatic logic [2:0] pat();
    return {vcc_en, data_en, bl_en};
  endfunction

  // bad counts illegal patterns (R2) and busy/ready mismatches (R10)
  task automatic sample(inout int bad2, inout int bad10);
    logic [2:0] p;
    p = pat();
    if (!(p == 3'b000 || p == 3'b100 || p == 3'b110 || p == 3'b111)) bad2++;
    if (busy != (p == 3'b100 || p == 3'b110) || ready != !busy) bad10++;
  endtask

  task automatic run_up(output int c1, output int t1, output int c2, output int t2);
    int bad2, bad10, n;
    c1 = 0; t1 = 0; c2 = 0; t2 = 0; bad2 = 0; bad10 = 0; n = 0;
    pwr_req = 1'b1;
    do begin
      @(negedge clk);
      n++;
      sample(bad2, bad10);
      if (pat() == 3'b100) begin c1++; if (u_tick_seen()) t1++; end
      if (pat() == 3'b110) begin c2++; if (u_tick_seen()) t2++; end
    end while (pat() != 3'b111 && n < LIMIT);
    chk("R2 up illegal enable pattern", bad2, 0);
    chk("R10 up busy/ready", bad10, 0);
    chk("R2 up reached full on", int'(pat()), 7);
  endtask

  task automatic run_down(output int c1, output int t1, output int c2, output int t2);
    int bad2, bad10, n;
    c1 = 0; t1 = 0; c2 = 0; t2 = 0; bad2 = 0; bad10 = 0; n = 0;
    pwr_req = 1'b0;
    @(negedge clk);
    chk("R5 backlight off first", int'(pat()), 6);
    do begin
      sample(bad2, bad10);
      if (pat() == 3'b110) begin c1++; if (u_tick_seen()) t1++; end
      if (pat() == 3'b100) begin c2++; if (u_tick_seen()) t2++; end
      if (pat() != 3'b000) @(negedge clk);
      n++;
    end while (pat() != 3'b000 && n < LIMIT);
    chk("R2 down illegal enable pattern", bad2, 0);
    chk("R10 down busy/ready", bad10, 0);
    chk("R6 down reached off", int'(pat()), 0);
  endtask

  // tick that the design consumes at the coming edge
  function automatic logic u_tick_seen();
    return use_ext_tick ? ext_tick : 1'b0;
  endfunction

  task automatic set_gaps(input int a, input int b, input int c, input int d);
    rise_gap_sd = 16'(a); rise_gap_db = 16'(b);
    fall_gap_bd = 16'(c); fall_gap_ds = 16'(d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c1, t1, c2, t2, n, offc, seen;
    rst_n = 1'b0; pwr_req = 1'b0; use_ext_tick = 1'b1; presc_div = 16'd0;
    set_gaps(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R1 reset enables", int'(pat()), 0);
    chk("R1 reset ready", int'(ready), 1);
    chk("R1 reset busy", int'(busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", int'({pat(), busy, ready}), 1);

    // R3 R4 R5 R6: full sweep of gap values 0..3
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++) begin
            set_gaps(a, b, c, d);
            run_up(c1, t1, c2, t2);
            chk_gap("R3 supply-to-data gap", a, c1, t1);
            chk_gap("R4 data-to-backlight gap", b, c2, t2);
            @(negedge clk);
            run_down(c1, t1, c2, t2);
            chk_gap("R6 backlight-to-data gap", c, c1, t1);
            chk_gap("R6 data-to-supply gap", d, c2, t2);
            @(negedge clk);
          end

    // R7: abort while only supply is on
    set_gaps(6, 1, 3, 2);
    pwr_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 in supply-only step", int'(pat()), 4);
    pwr_req = 1'b0;
    t1 = 0; seen = 0; n = 0;
    do begin
      @(negedge clk); n++;
      if (data_en) seen = 1;
      if (pat() == 3'b100 && ext_tick) t1++;
    end while (pat() != 3'b000 && n < LIMIT);
    chk("R7 data never enabled", seen, 0);
    chk("R7 supply hold ticks", t1, 2);
    @(negedge clk);

    // R8: abort while supply and data are on
    set_gaps(1, 8, 3, 2);
    pwr_req = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (pat() != 3'b110 && n < LIMIT);
    @(negedge clk);
    pwr_req = 1'b0;
    t1 = 0; t2 = 0; seen = 0; n = 0;
    do begin
      @(negedge clk); n++;
      if (bl_en) seen = 1;
      if (pat() == 3'b110 && ext_tick) t1++;
      if (pat() == 3'b100 && ext_tick) t2++;
    end while (pat() != 3'b000 && n < LIMIT);
    chk("R8 backlight never enabled", seen, 0);
    chk("R8 data hold ticks", t1, 3);
    chk("R8 supply hold ticks", t2, 2);
    @(negedge clk);

    // R9: request raised during power-down
    set_gaps(2, 2, 2, 2);
    run_up(c1, t1, c2, t2);
    @(negedge clk);
    pwr_req = 1'b0;
    @(negedge clk);
    chk("R9 in shutdown", int'(pat()), 6);
    pwr_req = 1'b1;
    offc = 0; n = 0;
    do begin
      @(negedge clk); n++;
      if (pat() == 3'b000) offc++;
    end while (!(offc > 0 && vcc_en) && n < LIMIT);
    chk("R9 one full-off cycle before restart", offc, 1);
    run_up(c1, t1, c2, t2);
    @(negedge clk);
    run_down(c1, t1, c2, t2);
    @(negedge clk);

    // R11: internal prescaler, external tick held high and ignored
    use_ext_tick = 1'b0; tick_force = 1'b1; presc_div = 16'd4;
    set_gaps(3, 1, 1, 1);
    @(negedge clk);
    run_up(c1, t1, c2, t2);
    checks++;
    if (c1 < 10 || c1 > 16) begin
      errors++;
      $display("FAIL R11 divided gap cycles actual=%0d expected=10..16", c1);
    end
    @(negedge clk);
    run_down(c1, t1, c2, t2);
    presc_div = 16'd0;
    set_gaps(3, 2, 1, 1);
    @(negedge clk);
    run_up(c1, t1, c2, t2);
    chk("R11 undivided first gap cycles", c1, 4);
    chk("R11 undivided second gap cycles", c2, 3);
    @(negedge clk);
    run_down(c1, t1, c2, t2);
    chk("R11 undivided fall gap cycles", c1, 2);

    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule